// File: doc/BRIEF.md
# USB Clock Request and Wake Controller

This block sits beside a USB device controller and decides when that controller's clocks must run. Software sets one enable bit for each gated clock: the device clock and the bus-slave clock. The block turns these into request lines toward the clock gating cells. Each gating cell answers with an acknowledge. The block passes each acknowledge through a two-flop synchronizer and uses the result as a status bit, so software sees the real state of each clock and not the state it asked for.

The block combines the status bits into a need-clock output for the power manager. While that output is low the chip may enter deep power-down. Line activity seen while the device is suspended forces need-clock high at once. Each rise of need-clock raises a wake request when waking on USB is allowed. Software may ask for a remote wake-up (resume). The block accepts that request only when both clocks are confirmed running. Otherwise it sets a sticky error flag.

Top module: `usb_clkwake_ctrl`

## Requirements
- R1: After reset the control register (address 0) and the status register (address 1) read zero. Need-clock, wake request, resume pulse and both clock requests are low, given that the peripheral power-enable input is low.
- R2: The device-clock request equals control bit 0. The bus-slave-clock request is high when control bit 1 is set or the peripheral power-enable input is high.
- R3: Status bit 0 (device clock) and status bit 1 (bus-slave clock) follow their acknowledge inputs two clock edges later. A bit rises or falls only when its acknowledge does, and never at the register write.
- R4: Need-clock is high whenever either status bit is one. It is low only when both status bits are zero and no line-activity wake is pending.
- R5: Line activity while the suspend input is high drives need-clock high in the same cycle, whatever the enable bits are. This stays latched until suspend falls. Activity without suspend has no effect.
- R6: When the wake-enable input is high, a rise of need-clock gives a wake-request pulse of exactly one cycle on the next edge. When wake-enable is low, no pulse is given.
- R7: Bit 0 of the interrupt status register (address 2) reads the current need-clock level. Every read returns data one cycle after the address is presented.
- R8: Writing 1 to bit 0 of the resume register (address 3) while both status bits are one gives a one-cycle resume pulse on the next edge.
- R9: A resume write made while either status bit is zero gives no pulse and sets the sticky error flag, read as interrupt status bit 1. Writing 1 to that bit clears the flag.
- R10: Writes to the status register are ignored, and the status register keeps reading the acknowledged state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the address |
| periph_pwr_en | input | 1 | Peripheral power enable; keeps the bus-slave clock requested |
| usb_wake_en | input | 1 | Allows need-clock rises to wake the chip |
| usb_suspend | input | 1 | Suspend indication from the line interface |
| bus_activity | input | 1 | Line activity seen by the line interface |
| dev_clk_req | output | 1 | Request to the device-clock gating cell |
| bus_clk_req | output | 1 | Request to the bus-slave-clock gating cell |
| dev_clk_ack | input | 1 | Device clock running, from its gating cell |
| bus_clk_ack | input | 1 | Bus-slave clock running, from its gating cell |
| need_clk | output | 1 | High while the controller needs its clocks |
| wake_req | output | 1 | One-cycle wake request to the power manager |
| resume_pulse | output | 1 | One-cycle accepted remote wake-up request |

## Verification
Two events can meet in one cycle: the last clock status bit falling to zero, and line activity arriving during suspend. If the block handles this badly, need-clock drops for one cycle and then rises again, which sends a false wake request. The bench removes the device-clock acknowledge while suspended with wake-enable set. It then raises line activity so that the activity is already latched on the edge where the synchronized status clears. The check is that need-clock stays high in every cycle and that the wake request never pulses.

// File: rtl/usbcw_pkg.sv
package usbcw_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 2;
    localparam int NCLK     = 2;
    localparam int SYNC_STG = 2;

    localparam int CLK_DEV  = 0;
    localparam int CLK_BUS  = 1;

    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT   = 2'd1;
    localparam logic [ADDR_W-1:0] A_INT    = 2'd2;
    localparam logic [ADDR_W-1:0] A_RESUME = 2'd3;

    localparam int INT_NEED_BIT = 0;
    localparam int INT_ERR_BIT  = 1;

    typedef struct packed {
        logic [NCLK-1:0]   ctrl;
        logic              err;
        logic              resume;
        logic [DATA_W-1:0] rdata;
    } regs_st_t;

    typedef struct packed {
        logic act;
        logic need_prev;
        logic wake;
    } wake_st_t;
endpackage

// File: rtl/usbcw_ack_sync.sv
module usbcw_ack_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ack_i,
    output logic [N-1:0] stat_o
);
    logic [STAGES-1:0] chain_d [N];
    logic [STAGES-1:0] chain_q [N];

    for (genvar g = 0; g < N; g++) begin : g_clk
        always_comb begin
            chain_d[g] = {chain_q[g][STAGES-2:0], ack_i[g]};
        end

        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[g] <= '0;
            else        chain_q[g] <= chain_d[g];
        end

        assign stat_o[g] = chain_q[g][STAGES-1];
    end
endmodule

// File: rtl/usbcw_regs.sv
module usbcw_regs
    import usbcw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NCLK-1:0]   stat_i,
    input  logic              need_i,
    output logic [NCLK-1:0]   ctrl_o,
    output logic              err_o,
    output logic              resume_o,
    output logic [DATA_W-1:0] rdata_o
);
    regs_st_t st_d, st_q;
    logic     resume_wr;
    logic     all_on;

    always_comb begin
        st_d      = st_q;
        all_on    = &stat_i;
        resume_wr = we_i && (addr_i == A_RESUME) && wdata_i[0];

        if (we_i && addr_i == A_CTRL)
            st_d.ctrl = wdata_i[NCLK-1:0];

        st_d.resume = resume_wr && all_on;

        if (we_i && addr_i == A_INT && wdata_i[INT_ERR_BIT])
            st_d.err = 1'b0;
        if (resume_wr && !all_on)
            st_d.err = 1'b1;

        st_d.rdata = '0;
        case (addr_i)
            A_CTRL:  st_d.rdata[NCLK-1:0] = st_q.ctrl;
            A_STAT:  st_d.rdata[NCLK-1:0] = stat_i;
            A_INT: begin
                st_d.rdata[INT_NEED_BIT] = need_i;
                st_d.rdata[INT_ERR_BIT]  = st_q.err;
            end
            default: st_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o   = st_q.ctrl;
    assign err_o    = st_q.err;
    assign resume_o = st_q.resume;
    assign rdata_o  = st_q.rdata;
endmodule

// File: rtl/usbcw_wake.sv
module usbcw_wake
    import usbcw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCLK-1:0] stat_i,
    input  logic            suspend_i,
    input  logic            activity_i,
    input  logic            wake_en_i,
    output logic            need_o,
    output logic            wake_o
);
    wake_st_t st_d, st_q;
    logic     act_now;
    logic     need;

    always_comb begin
        act_now      = suspend_i && activity_i;
        need         = (|stat_i) || st_q.act || act_now;
        st_d         = st_q;
        st_d.act     = suspend_i && (st_q.act || activity_i);
        st_d.need_prev = need;
        st_d.wake    = wake_en_i && need && !st_q.need_prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign need_o = need;
    assign wake_o = st_q.wake;
endmodule

// File: rtl/usb_clkwake_ctrl.sv
module usb_clkwake_ctrl
    import usbcw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              periph_pwr_en,
    input  logic              usb_wake_en,
    input  logic              usb_suspend,
    input  logic              bus_activity,
    output logic              dev_clk_req,
    output logic              bus_clk_req,
    input  logic              dev_clk_ack,
    input  logic              bus_clk_ack,
    output logic              need_clk,
    output logic              wake_req,
    output logic              resume_pulse
);
    logic [NCLK-1:0] ctrl;
    logic [NCLK-1:0] ack;
    logic [NCLK-1:0] clk_stat;
    logic            err_flag;

    assign ack[CLK_DEV] = dev_clk_ack;
    assign ack[CLK_BUS] = bus_clk_ack;

    usbcw_ack_sync #(.N(NCLK), .STAGES(SYNC_STG)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ack_i  (ack),
        .stat_o (clk_stat)
    );

    usbcw_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (reg_addr),
        .we_i     (reg_we),
        .wdata_i  (reg_wdata),
        .stat_i   (clk_stat),
        .need_i   (need_clk),
        .ctrl_o   (ctrl),
        .err_o    (err_flag),
        .resume_o (resume_pulse),
        .rdata_o  (reg_rdata)
    );

    usbcw_wake u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_i     (clk_stat),
        .suspend_i  (usb_suspend),
        .activity_i (bus_activity),
        .wake_en_i  (usb_wake_en),
        .need_o     (need_clk),
        .wake_o     (wake_req)
    );

    assign dev_clk_req = ctrl[CLK_DEV];
    assign bus_clk_req = ctrl[CLK_BUS] || periph_pwr_en;
endmodule

// File: rtl/usbcw_checker.sv
module usbcw_checker
    import usbcw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              periph_pwr_en,
    input logic              usb_wake_en,
    input logic              bus_clk_req,
    input logic              dev_clk_ack,
    input logic [NCLK-1:0]   clk_stat,
    input logic              err_flag,
    input logic              need_clk,
    input logic              wake_req,
    input logic              resume_pulse
);
    p_bus_pwr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        periph_pwr_en |-> bus_clk_req);

    p_stat_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_stat[CLK_DEV]) |-> $past(dev_clk_ack, 2));

    p_need_or_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|clk_stat) |-> need_clk);

    p_wake_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(need_clk) && usb_wake_en) |=> wake_req);

    p_wake_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !wake_req);

    p_resume_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |-> $past(&clk_stat));

    p_resume_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_RESUME && reg_wdata[0] && !(&clk_stat))
        |=> (!resume_pulse && err_flag));
endmodule

bind usb_clkwake_ctrl usbcw_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_addr      (reg_addr),
    .reg_we        (reg_we),
    .reg_wdata     (reg_wdata),
    .periph_pwr_en (periph_pwr_en),
    .usb_wake_en   (usb_wake_en),
    .bus_clk_req   (bus_clk_req),
    .dev_clk_ack   (dev_clk_ack),
    .clk_stat      (clk_stat),
    .err_flag      (err_flag),
    .need_clk      (need_clk),
    .wake_req      (wake_req),
    .resume_pulse  (resume_pulse)
);

// File: tb/sim_usb_clkwake_ctrl.sv
`timescale 1ns/1ps
module sim_usb_clkwake_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  reg_addr;
    logic        reg_we;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        periph_pwr_en, usb_wake_en, usb_suspend, bus_activity;
    logic        dev_clk_req, bus_clk_req, dev_clk_ack, bus_clk_ack;
    logic        need_clk, wake_req, resume_pulse;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    usb_clkwake_ctrl u0 (.*);

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        tick();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a; reg_we = 1'b0;
        tick();
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); chk("R1 ctrl", d, 0);
        rd(2'd1, d); chk("R1 stat", d, 0);
        chk("R1 outs", {need_clk, wake_req, resume_pulse, dev_clk_req, bus_clk_req}, 0);
    endtask

    task automatic t_requests();
        wr(2'd0, 32'h1);
        chk("R2 dev req", {dev_clk_req, bus_clk_req}, 2'b10);
        periph_pwr_en = 1'b1; #1;
        chk("R2 bus by pwr", bus_clk_req, 1);
        wr(2'd0, 32'h2); periph_pwr_en = 1'b0; #1;
        chk("R2 bus by ctrl", {dev_clk_req, bus_clk_req}, 2'b01);
        wr(2'd0, 32'h0);
        chk("R2 all off", {dev_clk_req, bus_clk_req}, 0);
    endtask

    task automatic t_status();
        logic [31:0] d;
        usb_wake_en = 1'b0;
        dev_clk_ack = 1'b1;
        tick(); chk("R3 one edge", need_clk, 0);
        tick(); chk("R4 need on", need_clk, 1);
        chk("R6 no wake when disabled", wake_req, 0);
        rd(2'd1, d); chk("R3 stat dev", d, 1);
        chk("R6 still no wake", wake_req, 0);
        dev_clk_ack = 1'b0;
        tick(); chk("R3 fall lag", need_clk, 1);
        tick(); chk("R4 need off", need_clk, 0);
    endtask

    task automatic t_wake();
        logic [31:0] d;
        usb_wake_en = 1'b1;
        bus_clk_ack = 1'b1;
        tick(); tick();
        chk("R4 bus on", need_clk, 1);
        chk("R6 not yet", wake_req, 0);
        tick(); chk("R6 pulse", wake_req, 1);
        tick(); chk("R6 single", wake_req, 0);
        rd(2'd2, d); chk("R7 need bit", d, 32'h1);
        bus_clk_ack = 1'b0;
        tick(); tick();
        rd(2'd2, d); chk("R7 need clear", d, 0);
        usb_wake_en = 1'b0;
    endtask

    task automatic t_activity();
        usb_suspend = 1'b0; bus_activity = 1'b1; #1;
        chk("R5 no suspend", need_clk, 0);
        tick(); chk("R5 no latch", need_clk, 0);
        usb_suspend = 1'b1; #1;
        chk("R5 immediate", need_clk, 1);
        tick(); bus_activity = 1'b0; #1;
        chk("R5 latched", need_clk, 1);
        usb_suspend = 1'b0;
        tick(); chk("R5 release", need_clk, 0);
    endtask

    task automatic t_resume();
        logic [31:0] d;
        dev_clk_ack = 1'b1; bus_clk_ack = 1'b1;
        tick(); tick();
        wr(2'd3, 32'h1);
        chk("R8 pulse", resume_pulse, 1);
        tick(); chk("R8 single", resume_pulse, 0);
        rd(2'd2, d); chk("R8 no err", d, 32'h1);
        bus_clk_ack = 1'b0;
        tick(); tick();
        wr(2'd3, 32'h1);
        chk("R9 no pulse", resume_pulse, 0);
        rd(2'd2, d); chk("R9 err set", d, 32'h3);
        wr(2'd2, 32'h2);
        rd(2'd2, d); chk("R9 err clear", d, 32'h1);
    endtask

    task automatic t_ro();
        logic [31:0] d;
        wr(2'd1, 32'h0);
        rd(2'd1, d); chk("R10 stat kept", d, 32'h1);
        wr(2'd1, 32'h3);
        rd(2'd1, d); chk("R10 stat not set", d, 32'h1);
    endtask

    task automatic t_overlap();
        usb_wake_en = 1'b1; usb_suspend = 1'b1;
        dev_clk_ack = 1'b0;
        tick(); chk("R4 overlap need", need_clk, 1);
        bus_activity = 1'b1; #1;
        chk("R5 overlap need", need_clk, 1);
        tick(); bus_activity = 1'b0;
        chk("R5 stat gone need held", need_clk, 1);
        chk("R6 no false wake", wake_req, 0);
        tick(); chk("R6 no false wake late", wake_req, 0);
        chk("R5 still held", need_clk, 1);
        usb_suspend = 1'b0; usb_wake_en = 1'b0;
        tick(); chk("R4 all off", need_clk, 0);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
        periph_pwr_en = 1'b0; usb_wake_en = 1'b0; usb_suspend = 1'b0; bus_activity = 1'b0;
        dev_clk_ack = 1'b0; bus_clk_ack = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        t_reset();
        t_requests();
        t_status();
        t_wake();
        t_activity();
        t_resume();
        t_ro();
        t_overlap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule